// File: doc/BRIEF.md
# Regulator Soft-Start Sequencer

This block powers up a multiphase voltage regulator controller. It sits in shutdown, with its phase drivers released and its DAC code at zero, until three digitised qualifiers are all true: the bias power-on-reset result and two enable comparator results. It then times a fixed start-up delay and ramps the DAC code up to a fixed boot level. The ramp moves one code per soft-start tick, and one code stands for 6.25 mV.

At the boot level the block holds for a timed window. A filter watches the voltage-identification (VID) bus over this window and accepts a code only once it has stayed unchanged for a set number of clock cycles. When the window has run out and a code has been accepted, the block acts on that code.

- The all-ones OFF code latches the block off. It stays off until one of the qualifiers drops and returns.
- Any other code sets a target of that code minus a fixed offset, in steps. A second ramp then moves toward the target, up or down.

When the second ramp arrives, the block raises its ready flag and keeps regulating. If any qualifier drops, at any time, the block goes back to shutdown.

All timing windows are parameters in system-clock cycles. The current sequencer state is available as a debug output.

Top module: `vr_softstart_seq`

## Requirements
- R1: Unless `por_ok`, `en_pwr_ok` and `en_vtt_ok` are all 1, the block stays in shutdown (state code 0) with `pwm_oe` = 0, `dac_code` = 0 and `vr_ready` = 0.
- R2: The cycle after all three qualifiers are seen high, the block enters the delay state (code 1). It remains there for exactly `TD1_CYC` cycles with `dac_code` = 0 and `pwm_oe` = 1, then enters the first ramp (code 2).
- R3: In a ramp state, `dac_code` changes by exactly one code at each clock edge where `ss_tick` is 1, and it does not change at any other edge.
- R4: The first ramp climbs to `BOOT_CODE`. The cycle after `dac_code` reaches it, the block enters the hold state (code 3) and keeps `dac_code` at `BOOT_CODE`.
- R5: A VID value is accepted only after it has stayed unchanged for `STABLE_CYC` consecutive clock edges. The hold state lasts at least `HOLD_CYC` cycles; it lasts exactly `HOLD_CYC` cycles when the VID was already accepted, and otherwise it ends `STABLE_CYC`+1 cycles after the last VID change.
- R6: On an accepted VID other than the OFF code, the block enters the second ramp (code 4). The target is VID minus `OFFSET_STEPS`, floored at 0, and the ramp steps down when the target is below the boot level.
- R7: On the accepted OFF code (`OFF_CODE`, all ones by default), the block enters the off-latched state (code 6) with `pwm_oe` = 0 and `dac_code` = 0. It stays there while all qualifiers remain high. After a qualifier drops it goes to shutdown, and it requalifies as in R2.
- R8: `vr_ready` is 1 only in the regulate state (code 5). That state is entered the cycle after the second ramp's `dac_code` equals its target, and `dac_code` then holds the target.
- R9: In any state, the cycle after any qualifier is seen low, the block is in shutdown with `pwm_oe` = 0, `vr_ready` = 0 and `dac_code` = 0.
- R10: `state_dbg` encodes the states as: shutdown 0, delay 1, first ramp 2, hold 3, second ramp 4, regulate 5, off-latched 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| por_ok | input | 1 | Bias supply above its power-on-reset threshold |
| en_pwr_ok | input | 1 | Power-sequencing enable comparator result |
| en_vtt_ok | input | 1 | Termination-rail enable comparator result |
| vid | input | VID_W | Voltage-identification code from the processor |
| ss_tick | input | 1 | One-cycle soft-start oscillator step strobe |
| dac_code | output | DAC_W | Reference DAC code in 6.25 mV steps |
| pwm_oe | output | 1 | 1 drives the phase outputs, 0 leaves them high-impedance |
| vr_ready | output | 1 | Output is in its final regulation window |
| state_dbg | output | 3 | Current sequencer state (R10 encoding) |

## Verification
The sequencer state is one register, so every state change, and the `pwm_oe` and `vr_ready` values that follow from it, appears at the first clock edge after the qualifiers or the counters call for it. A DAC step appears at the same edge at which the tick is sampled. The hold exits `STABLE_CYC`+1 edges after the last VID change, because the filter first registers the new value and then counts `STABLE_CYC` matching edges. The bench drives every input on the falling edge and samples the outputs on the falling edge. Each expected value is tied to the rising edge in between: a record of the tick taken at that rising edge predicts each ramp step exactly, and the delay and hold windows are checked by counting the falling edges spent in each state.

// File: rtl/vrss_pkg.sv
`timescale 1ns/1ps
// Shared types for the soft-start sequencer.
// Assumes: the state codes are visible on a debug port and must not be renumbered.
package vrss_pkg;

    typedef enum logic [2:0] {
        ST_SHUT  = 3'd0,
        ST_DELAY = 3'd1,
        ST_RAMP1 = 3'd2,
        ST_HOLD  = 3'd3,
        ST_RAMP2 = 3'd4,
        ST_REG   = 3'd5,
        ST_OFF   = 3'd6
    } seq_state_e;

endpackage

// File: rtl/vrss_vid_filter.sv
`timescale 1ns/1ps
// VID stability filter: registers the bus and counts consecutive edges on which it is unchanged.
// Assumes: vid_in is already synchronised to clk; STABLE_CYC >= 1.
module vrss_vid_filter #(
    parameter int VID_W      = 8,
    parameter int STABLE_CYC = 125
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VID_W-1:0] vid_in,
    output logic [VID_W-1:0] vid_held,
    output logic             vid_valid
);
    localparam int CW = $clog2(STABLE_CYC + 1);
    localparam logic [CW-1:0] STABLE_MAX = CW'(STABLE_CYC);

    logic [VID_W-1:0] vid_q;
    logic [CW-1:0]    stable_cnt;

    // Capture the bus; restart the count on any change, saturate once it is long enough.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vid_q      <= '0;
            stable_cnt <= '0;
        end else begin
            vid_q <= vid_in;
            if (vid_in != vid_q)
                stable_cnt <= '0;
            else if (stable_cnt != STABLE_MAX)
                stable_cnt <= stable_cnt + 1'b1;
        end
    end

    assign vid_held  = vid_q;
    assign vid_valid = (stable_cnt == STABLE_MAX);

    // A change seen at an edge must withdraw acceptance after that edge.
    assert_change_clears_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (vid_in != vid_q) |=> !vid_valid);

endmodule

// File: rtl/vrss_ramp.sv
`timescale 1ns/1ps
// DAC ramp stepper: moves the code one step toward a target on each enabled tick.
// Assumes: clear has priority and comes from the sequencer's next-state decision.
module vrss_ramp #(
    parameter int DAC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic             tick,
    input  logic [DAC_W-1:0] target,
    output logic [DAC_W-1:0] dac
);
    logic [DAC_W-1:0] dac_q;

    // Step up or down by one code per tick while running; zero on clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dac_q <= '0;
        else if (clear)
            dac_q <= '0;
        else if (run && tick) begin
            if (dac_q < target)
                dac_q <= dac_q + 1'b1;
            else if (dac_q > target)
                dac_q <= dac_q - 1'b1;
        end
    end

    assign dac = dac_q;

    // Without a tick the code does not move.
    assert_no_step_without_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clear) |=> $stable(dac_q));

    // With a tick the code moves by at most one step.
    assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear) |=> (dac_q == $past(dac_q) || dac_q == $past(dac_q) + 1'b1
                      || dac_q == $past(dac_q) - 1'b1));

endmodule

// File: rtl/vrss_fsm.sv
`timescale 1ns/1ps
// Sequencer control: state register, shared window timer and second-ramp target register.
// Assumes: all_ok is the AND of the three qualifiers; VID_W <= DAC_W; TD1_CYC, HOLD_CYC >= 1.
module vrss_fsm
    import vrss_pkg::*;
#(
    parameter int VID_W        = 8,
    parameter int DAC_W        = 8,
    parameter int TD1_CYC      = 340000,
    parameter int HOLD_CYC     = 21250,
    parameter int BOOT_CODE    = 176,
    parameter int OFF_CODE     = 255,
    parameter int OFFSET_STEPS = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             all_ok,
    input  logic [VID_W-1:0] vid_held,
    input  logic             vid_valid,
    input  logic [DAC_W-1:0] dac,
    output seq_state_e       state,
    output logic             ramp_clear,
    output logic             ramp_run,
    output logic [DAC_W-1:0] ramp_target
);
    localparam int TMAX = (TD1_CYC > HOLD_CYC) ? TD1_CYC : HOLD_CYC;
    localparam int TW   = $clog2(TMAX + 1);
    localparam logic [TW-1:0]    TD1_LAST  = TW'(TD1_CYC - 1);
    localparam logic [TW-1:0]    HOLD_LAST = TW'(HOLD_CYC - 1);
    localparam logic [DAC_W-1:0] BOOT      = DAC_W'(BOOT_CODE);
    localparam logic [DAC_W-1:0] OFFSET    = DAC_W'(OFFSET_STEPS);
    localparam logic [VID_W-1:0] OFFV      = VID_W'(OFF_CODE);

    seq_state_e       state_q, nxt;
    logic [TW-1:0]    tmr;
    logic [DAC_W-1:0] tgt_q, vid_tgt, vid_ext;
    logic             take_vid;

    // Translate the held VID into a step target, floored at zero.
    always_comb begin
        vid_ext = DAC_W'(vid_held);
        vid_tgt = (vid_ext > OFFSET) ? (vid_ext - OFFSET) : '0;
    end

    // Next-state decision; losing any qualifier overrides every other transition.
    always_comb begin
        nxt      = state_q;
        take_vid = 1'b0;
        case (state_q)
            ST_SHUT:  if (all_ok) nxt = ST_DELAY;
            ST_DELAY: if (tmr >= TD1_LAST) nxt = ST_RAMP1;
            ST_RAMP1: if (dac == BOOT) nxt = ST_HOLD;
            ST_HOLD: begin
                if (tmr >= HOLD_LAST && vid_valid) begin
                    if (vid_held == OFFV)
                        nxt = ST_OFF;
                    else begin
                        nxt      = ST_RAMP2;
                        take_vid = 1'b1;
                    end
                end
            end
            ST_RAMP2: if (dac == tgt_q) nxt = ST_REG;
            ST_REG:   nxt = ST_REG;
            ST_OFF:   nxt = ST_OFF;
            default:  nxt = ST_SHUT;
        endcase
        if (!all_ok)
            nxt = ST_SHUT;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_SHUT;
        else        state_q <= nxt;
    end

    // Window timer: restarts on every state change and saturates at its top.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tmr <= '0;
        else if (nxt != state_q)
            tmr <= '0;
        else if (tmr != {TW{1'b1}})
            tmr <= tmr + 1'b1;
    end

    // Second-ramp target, captured when the VID is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)        tgt_q <= BOOT;
        else if (take_vid) tgt_q <= vid_tgt;
    end

    assign state       = state_q;
    assign ramp_run    = (state_q == ST_RAMP1) || (state_q == ST_RAMP2);
    assign ramp_target = (state_q == ST_RAMP2 || state_q == ST_REG) ? tgt_q : BOOT;
    assign ramp_clear  = (nxt == ST_SHUT) || (nxt == ST_OFF);

    // Shutdown is left only when all qualifiers are present.
    assert_stay_shut_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHUT && !all_ok) |=> (state_q == ST_SHUT));

    // The hold window cannot be cut short.
    assert_hold_minimum_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && tmr < HOLD_LAST && all_ok) |=> (state_q == ST_HOLD));

    // The off latch survives while the qualifiers stay high.
    assert_off_latched_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF && all_ok) |=> (state_q == ST_OFF));

    // Regulation means the stepper sits on the captured target.
    assert_regulate_on_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REG) |-> (dac == tgt_q));

    // A dropped qualifier forces shutdown at the next edge.
    assert_drop_to_shutdown_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!all_ok) |=> (state_q == ST_SHUT));

endmodule

// File: rtl/vr_softstart_seq.sv
`timescale 1ns/1ps
// Top of the soft-start sequencer: qualifies the enables, filters VID, steps the DAC code.
// Assumes: all inputs are synchronous to clk; ss_tick is a one-cycle strobe.
module vr_softstart_seq
    import vrss_pkg::*;
#(
    parameter int VID_W        = 8,
    parameter int DAC_W        = 8,
    parameter int TD1_CYC      = 340000,
    parameter int HOLD_CYC     = 21250,
    parameter int STABLE_CYC   = 125,
    parameter int BOOT_CODE    = 176,
    parameter int OFF_CODE     = 255,
    parameter int OFFSET_STEPS = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             por_ok,
    input  logic             en_pwr_ok,
    input  logic             en_vtt_ok,
    input  logic [VID_W-1:0] vid,
    input  logic             ss_tick,
    output logic [DAC_W-1:0] dac_code,
    output logic             pwm_oe,
    output logic             vr_ready,
    output logic [2:0]       state_dbg
);
    logic             all_ok;
    logic [VID_W-1:0] vid_held;
    logic             vid_valid;
    logic             ramp_clear, ramp_run;
    logic [DAC_W-1:0] ramp_target;
    seq_state_e       state;

    // All three qualifiers must be present together.
    assign all_ok = por_ok & en_pwr_ok & en_vtt_ok;

    vrss_vid_filter #(
        .VID_W      (VID_W),
        .STABLE_CYC (STABLE_CYC)
    ) i_vid_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .vid_in    (vid),
        .vid_held  (vid_held),
        .vid_valid (vid_valid)
    );

    vrss_fsm #(
        .VID_W        (VID_W),
        .DAC_W        (DAC_W),
        .TD1_CYC      (TD1_CYC),
        .HOLD_CYC     (HOLD_CYC),
        .BOOT_CODE    (BOOT_CODE),
        .OFF_CODE     (OFF_CODE),
        .OFFSET_STEPS (OFFSET_STEPS)
    ) i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .all_ok      (all_ok),
        .vid_held    (vid_held),
        .vid_valid   (vid_valid),
        .dac         (dac_code),
        .state       (state),
        .ramp_clear  (ramp_clear),
        .ramp_run    (ramp_run),
        .ramp_target (ramp_target)
    );

    vrss_ramp #(
        .DAC_W (DAC_W)
    ) i_ramp (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (ramp_clear),
        .run    (ramp_run),
        .tick   (ss_tick),
        .target (ramp_target),
        .dac    (dac_code)
    );

    // Phase outputs are driven except in shutdown and in the off latch.
    assign pwm_oe    = (state != ST_SHUT) && (state != ST_OFF);
    assign vr_ready  = (state == ST_REG);
    assign state_dbg = state;

    // The stepper is zeroed at the same edge that a lost qualifier forces shutdown.
    assert_dac_zero_on_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!all_ok) |=> (dac_code == '0 && !vr_ready && !pwm_oe));

    // Without all qualifiers the phase drivers are never enabled.
    assert_tristate_when_unqualified_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!all_ok && state == ST_SHUT) |=> !pwm_oe);

endmodule

// File: tb/test_vr_softstart_seq.sv
`timescale 1ns/1ps
// Directed bench for the soft-start sequencer; one task per scenario.
module test_vr_softstart_seq;
    localparam int TD1   = 20;
    localparam int HOLD  = 10;
    localparam int STB   = 5;
    localparam int BOOT  = 176;
    localparam int OFFS  = 2;

    logic       clk = 1'b0;
    logic       rst_n, por_ok, en_pwr_ok, en_vtt_ok, ss_tick, tick_en, tick_seen;
    logic [7:0] vid, dac_code;
    logic       pwm_oe, vr_ready;
    logic [2:0] state_dbg;
    int         vectors = 0, miscompares = 0, tphase = 0;

    always #2 clk = ~clk;

    vr_softstart_seq #(
        .TD1_CYC(TD1), .HOLD_CYC(HOLD), .STABLE_CYC(STB),
        .BOOT_CODE(BOOT), .OFF_CODE(255), .OFFSET_STEPS(OFFS)
    ) i_vr_softstart_seq (
        .clk(clk), .rst_n(rst_n), .por_ok(por_ok), .en_pwr_ok(en_pwr_ok),
        .en_vtt_ok(en_vtt_ok), .vid(vid), .ss_tick(ss_tick), .dac_code(dac_code),
        .pwm_oe(pwm_oe), .vr_ready(vr_ready), .state_dbg(state_dbg)
    );

    // Tick strobe one cycle in three, driven at the falling edge.
    always @(negedge clk) begin
        if (tick_en) begin
            tphase = (tphase + 1) % 3;
            ss_tick <= (tphase == 0);
        end else
            ss_tick <= 1'b0;
    end

    // Record the tick as the design saw it at the rising edge.
    always @(posedge clk) tick_seen <= ss_tick;

    task automatic chk(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_state(input string req, input int code, input int limit);
        int n = 0;
        while (state_dbg != code && n < limit) begin
            @(negedge clk);
            n++;
        end
        chk(req, "reached state", state_dbg, code);
    endtask

    // Follow one ramp; every step must match the tick seen at the rising edge before it.
    task automatic run_ramp(input string req, input int code, input int final_code,
                            input int next_code);
        int bad = 0, rdy = 0, n = 0, prev, exp;
        while (state_dbg == code && n < 5000) begin
            prev = dac_code;
            @(negedge clk);
            n++;
            exp = prev;
            if (tick_seen && prev != final_code)
                exp = (final_code > prev) ? prev + 1 : prev - 1;
            if (state_dbg != 0 && dac_code != exp) bad++;
            if (state_dbg == code && vr_ready) rdy++;
        end
        chk(req, "ramp step mismatches", bad, 0);
        chk(req, "ready during ramp", rdy, 0);
        chk(req, "final code", dac_code, final_code);
        chk(req, "state after ramp", state_dbg, next_code);
    endtask

    task automatic t_reset;
        chk("R1", "reset state", state_dbg, 0);
        chk("R1", "reset dac", dac_code, 0);
        chk("R1", "reset pwm_oe", pwm_oe, 0);
        chk("R10", "reset ready", vr_ready, 0);
    endtask

    task automatic t_partial_enable;
        int bad = 0;
        por_ok = 1'b1; en_pwr_ok = 1'b1; en_vtt_ok = 1'b0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (state_dbg != 0 || pwm_oe || dac_code != 0) bad++;
        end
        chk("R1", "two of three qualifiers leave shutdown", bad, 0);
    endtask

    task automatic t_delay;
        int cnt = 0, bad = 0;
        en_vtt_ok = 1'b1;
        @(negedge clk);
        while (state_dbg == 1 && cnt < 1000) begin
            cnt++;
            if (dac_code != 0 || !pwm_oe) bad++;
            @(negedge clk);
        end
        chk("R2", "cycles in delay", cnt, TD1);
        chk("R2", "delay outputs wrong", bad, 0);
        chk("R10", "first ramp code", state_dbg, 2);
    endtask

    task automatic t_hold(input string req, input int exp_cycles);
        int cnt = 0, bad = 0;
        while (state_dbg == 3 && cnt < 1000) begin
            cnt++;
            if (dac_code != BOOT) bad++;
            @(negedge clk);
        end
        chk(req, "cycles in hold", cnt, exp_cycles);
        chk("R4", "dac off boot during hold", bad, 0);
    endtask

    task automatic t_drop;
        por_ok = 1'b0;
        @(negedge clk);
        chk("R9", "state after drop", state_dbg, 0);
        chk("R9", "dac after drop", dac_code, 0);
        chk("R9", "pwm_oe after drop", pwm_oe, 0);
        chk("R9", "ready after drop", vr_ready, 0);
    endtask

    task automatic t_vid_unstable;
        int cnt = 0;
        vid = 8'd100;
        por_ok = 1'b1;
        wait_state("R5", 3, 2000);
        for (int i = 0; i < HOLD + 5; i++) begin
            vid = (i % 2 == 0) ? 8'd101 : 8'd100;
            @(negedge clk);
        end
        vid = 8'd100;
        @(negedge clk);
        while (state_dbg == 3 && cnt < 100) begin
            cnt++;
            @(negedge clk);
        end
        chk("R5", "hold cycles after last VID change", cnt, STB + 1);
        chk("R6", "second ramp entered", state_dbg, 4);
        run_ramp("R6", 4, 100 - OFFS, 5);
        chk("R8", "ready after downward ramp", vr_ready, 1);
    endtask

    task automatic t_off_code;
        int bad = 0;
        en_pwr_ok = 1'b0;
        @(negedge clk);
        vid = 8'hFF;
        en_pwr_ok = 1'b1;
        wait_state("R7", 6, 2000);
        chk("R7", "pwm_oe in off latch", pwm_oe, 0);
        chk("R7", "dac in off latch", dac_code, 0);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (state_dbg != 6 || pwm_oe || vr_ready) bad++;
        end
        chk("R7", "left off latch with qualifiers high", bad, 0);
        en_vtt_ok = 1'b0;
        @(negedge clk);
        chk("R7", "shutdown after cycling qualifier", state_dbg, 0);
        vid = 8'd180;
        en_vtt_ok = 1'b1;
        @(negedge clk);
        chk("R7", "requalified into delay", state_dbg, 1);
    endtask

    initial begin
        rst_n = 1'b0; por_ok = 1'b0; en_pwr_ok = 1'b0; en_vtt_ok = 1'b0;
        vid = 8'd180; ss_tick = 1'b0; tick_en = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_partial_enable();
        tick_en = 1'b1;
        t_delay();
        run_ramp("R3", 2, BOOT, 3);
        chk("R4", "boot level after first ramp", dac_code, BOOT);
        t_hold("R5", HOLD);
        run_ramp("R6", 4, 180 - OFFS, 5);
        chk("R8", "ready in regulate", vr_ready, 1);
        chk("R10", "regulate code", state_dbg, 5);
        t_drop();
        t_vid_unstable();
        t_off_code();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    // Watchdog: a hung run is reported as one more failure.
    initial begin
        #(200000 * 4);
        vectors++;
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule